// File: doc/BRIEF.md
# Shared Arithmetic Unit Crossbar

This block lets a group of processor cores share a smaller pool of arithmetic units. There are 2^CORE_LOG core-side ports and 2^UNIT_LOG units. Every unit holds two fully pipelined lanes: an adder/subtractor with a latency of ADD_LAT cycles and a multiplier with a latency of MUL_LAT cycles. A core presents two operands and an opcode. In the same cycle it learns whether a lane took the request. The core's port index goes along with the operation as a tag. When the operation finishes, the lane returns a valid bit, the tag and the result on its own response path, and the crossbar steers that result back to the core that sent the request.

The units have no flow control, so an accepted operation always completes after the fixed latency of its lane. Two lanes with different latencies could finish work for the same core in the same cycle. To prevent this, the issue logic keeps a per-core record of the cycles in which results are still due, and it refuses any new request whose result would land in a cycle that is already taken. Competing cores are served in rotating priority order. Unit selection is fixed at build time to one of two policies. One packs requests onto the lowest-numbered free lanes. The other starts its search at a pseudo-random unit each cycle.

Top module: `fu_share_xbar`

## Requirements
- R1: While reset is held and in the first cycle after it, no core sees a response valid.
- R2: The grant is combinational: a request is accepted in the same cycle it is presented. A core with no valid request is never granted.
- R3: The opcode encoding is 2'b00 = add (A+B), 2'b01 = subtract (A-B), and 2'b10 or 2'b11 = multiply (the low DW bits of A*B). All results are truncated to DW bits.
- R4: In one cycle, at most 2^UNIT_LOG add/subtract requests and at most 2^UNIT_LOG multiply requests are granted. Each granted request goes to a different lane of its type. Requests beyond that limit are refused.
- R5: A request granted in cycle t returns its result on the requesting core's response port in cycle t+ADD_LAT for add/subtract, or in cycle t+MUL_LAT for multiply.
- R6: A core never receives two responses in one cycle. A request whose completion cycle is already reserved for that core is refused, even when a lane is free.
- R7: A priority pointer picks the first core to be served. Service then goes upward from that core and wraps around. The pointer is 0 after reset. It advances by one after every cycle in which a request that did not clash was refused for lack of a lane.
- R8: The random-start unit policy grants the same set of cores and returns the same results in the same cycles as the lowest-index policy. Only the lane choice differs.
- R9: Each lane accepts a new operation every cycle. A single core with no competitors and no clashes is granted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NC | Per-core request present |
| req_op | input | NC x 2 | Per-core opcode (see R3) |
| req_a | input | NC x DW | Per-core operand A |
| req_b | input | NC x DW | Per-core operand B |
| req_gnt | output | NC | Per-core combinational accept |
| rsp_valid | output | NC | Per-core result valid |
| rsp_data | output | NC x DW | Per-core result |

## Verification
The bench targets completion clashes. One core issues two multiplies and then an add whose result would fall in the same cycle as an earlier multiply. A design that does not reserve completion cycles would either drop a result or merge two results into one. The bench also drives four cores against two adders at once: wrong rotation shows up as a different set of grants, and an over-grant shows up as a lost result. A long single-core multiply stream exposes a lane that is not fully pipelined, because it stretches the grant pattern. Finally, a second instance built with the random-start policy must agree cycle for cycle with the first.

// File: rtl/fsx_pkg.sv
package fsx_pkg;

   typedef enum logic [1:0] {
      FSX_ADD     = 2'b00,
      FSX_SUB     = 2'b01,
      FSX_MUL     = 2'b10,
      FSX_MUL_ALT = 2'b11
   } fsx_op_e;

   // bit 1 of the opcode selects the multiply lane
   function automatic logic op_is_mul(input logic [1:0] op);
      return op[1];
   endfunction

   // bit 0 selects subtraction on the add lane
   function automatic logic op_is_sub(input logic [1:0] op);
      return op[0];
   endfunction

endpackage

// File: rtl/fsx_lane_pipe.sv
// Fixed-latency pipeline lane with a tag that travels beside the data.
module fsx_lane_pipe #(
   parameter int DW  = 16,
   parameter int TW  = 2,
   parameter int LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [TW-1:0] in_tag,
   input  logic [DW-1:0] in_data,
   output logic          out_v,
   output logic [TW-1:0] out_tag,
   output logic [DW-1:0] out_data
);

   if (LAT < 1) begin : g_bad_lat
      $error("fsx_lane_pipe: LAT must be at least 1");
   end

   logic [LAT-1:0]         v_q;
   logic [LAT-1:0][TW-1:0] t_q;
   logic [LAT-1:0][DW-1:0] d_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q[0] <= in_v;
         for (int k = 1; k < LAT; k++) begin
            v_q[k] <= v_q[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      t_q[0] <= in_tag;
      d_q[0] <= in_data;
      for (int k = 1; k < LAT; k++) begin
         t_q[k] <= t_q[k-1];
         d_q[k] <= d_q[k-1];
      end
   end

   assign out_v    = v_q[LAT-1];
   assign out_tag  = t_q[LAT-1];
   assign out_data = d_q[LAT-1];

endmodule

// File: rtl/fsx_unit.sv
// One shared unit: an add/sub lane and a multiply lane, each with its own response path.
module fsx_unit #(
   parameter int DW      = 16,
   parameter int TW      = 2,
   parameter int ADD_LAT = 2,
   parameter int MUL_LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_v,
   input  logic          add_sub,
   input  logic [TW-1:0] add_tag,
   input  logic [DW-1:0] add_a,
   input  logic [DW-1:0] add_b,
   input  logic          mul_v,
   input  logic [TW-1:0] mul_tag,
   input  logic [DW-1:0] mul_a,
   input  logic [DW-1:0] mul_b,
   output logic          add_ov,
   output logic [TW-1:0] add_otag,
   output logic [DW-1:0] add_od,
   output logic          mul_ov,
   output logic [TW-1:0] mul_otag,
   output logic [DW-1:0] mul_od
);

   logic [DW-1:0] add_res;
   logic [DW-1:0] mul_res;

   assign add_res = add_sub ? (add_a - add_b) : (add_a + add_b);
   assign mul_res = mul_a * mul_b;

   fsx_lane_pipe #(.DW(DW), .TW(TW), .LAT(ADD_LAT)) u_add_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (add_v),
      .in_tag   (add_tag),
      .in_data  (add_res),
      .out_v    (add_ov),
      .out_tag  (add_otag),
      .out_data (add_od)
   );

   fsx_lane_pipe #(.DW(DW), .TW(TW), .LAT(MUL_LAT)) u_mul_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (mul_v),
      .in_tag   (mul_tag),
      .in_data  (mul_res),
      .out_v    (mul_ov),
      .out_tag  (mul_otag),
      .out_data (mul_od)
   );

endmodule

// File: rtl/fsx_slot_track.sv
// Per-core record of future cycles that already carry a result for this core.
module fsx_slot_track #(
   parameter int ADD_LAT = 2,
   parameter int MUL_LAT = 4,
   localparam int MAXL   = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic issue_mul,
   output logic block_add,
   output logic block_mul
);

   // busy_q[i] set: a result for this core lands i+1 cycles from now
   logic [MAXL-1:0] busy_q;
   logic [MAXL-1:0] busy_d;
   int              new_lat;

   assign new_lat = issue_mul ? MUL_LAT : ADD_LAT;

   always_comb begin
      for (int i = 0; i < MAXL; i++) begin
         busy_d[i] = ((i + 1 < MAXL) ? busy_q[(i + 1) % MAXL] : 1'b0)
                     | (issue && (new_lat == i + 2));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= '0;
      else        busy_q <= busy_d;
   end

   assign block_add = busy_q[ADD_LAT-1];
   assign block_mul = busy_q[MUL_LAT-1];

endmodule

// File: rtl/fsx_alloc.sv
// Grant logic: rotating core priority, per-type lane search with a selectable start point.
module fsx_alloc #(
   parameter int NC          = 4,
   parameter int NU          = 2,
   parameter int TW          = 2,
   parameter int UW          = 1,
   parameter bit RANDOM_PICK = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NC-1:0]          req_v,
   input  logic [NC-1:0]          want_mul,
   input  logic [NC-1:0]          blocked,
   output logic [NC-1:0]          gnt,
   output logic [NC-1:0][UW-1:0]  sel
);

   logic [TW-1:0] ptr_q;
   int            start_off;
   logic          refused;
   logic [NU-1:0] used_add;
   logic [NU-1:0] used_mul;
   int            cidx;
   int            uidx;
   logic          hit;

   if (RANDOM_PICK) begin : g_rand_start
      logic [15:0] lfsr_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lfsr_q <= 16'hACE1;
         else        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      end
      assign start_off = int'(lfsr_q) % NU;
   end else begin : g_low_start
      assign start_off = 0;
   end

   always_comb begin
      gnt      = '0;
      sel      = '0;
      used_add = '0;
      used_mul = '0;
      refused  = 1'b0;
      cidx     = 0;
      uidx     = 0;
      hit      = 1'b0;
      for (int i = 0; i < NC; i++) begin
         cidx = (int'(ptr_q) + i) % NC;
         if (req_v[cidx] && !blocked[cidx]) begin
            hit = 1'b0;
            for (int j = 0; j < NU; j++) begin
               uidx = (start_off + j) % NU;
               if (!hit && (want_mul[cidx] ? !used_mul[uidx] : !used_add[uidx])) begin
                  hit        = 1'b1;
                  gnt[cidx]  = 1'b1;
                  sel[cidx]  = UW'(uidx);
                  if (want_mul[cidx]) used_mul[uidx] = 1'b1;
                  else                used_add[uidx] = 1'b1;
               end
            end
            if (!hit) refused = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= '0;
      else if (refused) ptr_q <= TW'((int'(ptr_q) + 1) % NC);
   end

endmodule

// File: rtl/fu_share_xbar.sv
// Crossbar sharing 2^UNIT_LOG pipelined arithmetic units among 2^CORE_LOG cores.
module fu_share_xbar #(
   parameter int  CORE_LOG    = 2,
   parameter int  UNIT_LOG    = 1,
   parameter int  DW          = 16,
   parameter int  ADD_LAT     = 2,
   parameter int  MUL_LAT     = 4,
   parameter bit  RANDOM_PICK = 1'b0,
   localparam int NC          = 1 << CORE_LOG,
   localparam int NU          = 1 << UNIT_LOG,
   localparam int TW          = (CORE_LOG > 0) ? CORE_LOG : 1,
   localparam int UW          = (UNIT_LOG > 0) ? UNIT_LOG : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NC-1:0]         req_valid,
   input  logic [NC-1:0][1:0]    req_op,
   input  logic [NC-1:0][DW-1:0] req_a,
   input  logic [NC-1:0][DW-1:0] req_b,
   output logic [NC-1:0]         req_gnt,
   output logic [NC-1:0]         rsp_valid,
   output logic [NC-1:0][DW-1:0] rsp_data
);
   import fsx_pkg::*;

   if (ADD_LAT < 1 || MUL_LAT < 1) begin : g_bad_lat
      $error("fu_share_xbar: lane latencies must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("fu_share_xbar: DW must be at least 2");
   end
   if (CORE_LOG < 0 || UNIT_LOG < 0) begin : g_bad_log
      $error("fu_share_xbar: port counts are powers of two with non-negative exponents");
   end

   logic [NC-1:0]         want_mul;
   logic [NC-1:0]         blk_add;
   logic [NC-1:0]         blk_mul;
   logic [NC-1:0]         blocked;
   logic [NC-1:0]         gnt;
   logic [NC-1:0][UW-1:0] sel;

   logic [NU-1:0]         add_v, add_sub, mul_v;
   logic [NU-1:0][TW-1:0] add_tag, mul_tag;
   logic [NU-1:0][DW-1:0] add_a, add_b, mul_a, mul_b;
   logic [NU-1:0]         add_ov, mul_ov;
   logic [NU-1:0][TW-1:0] add_otag, mul_otag;
   logic [NU-1:0][DW-1:0] add_od, mul_od;

   // per-core completion-slot reservation
   for (genvar c = 0; c < NC; c++) begin : g_core
      assign want_mul[c] = op_is_mul(req_op[c]);
      assign blocked[c]  = want_mul[c] ? blk_mul[c] : blk_add[c];

      fsx_slot_track #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_slots (
         .clk       (clk),
         .rst_n     (rst_n),
         .issue     (gnt[c]),
         .issue_mul (want_mul[c]),
         .block_add (blk_add[c]),
         .block_mul (blk_mul[c])
      );
   end

   fsx_alloc #(
      .NC(NC), .NU(NU), .TW(TW), .UW(UW), .RANDOM_PICK(RANDOM_PICK)
   ) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_v    (req_valid),
      .want_mul (want_mul),
      .blocked  (blocked),
      .gnt      (gnt),
      .sel      (sel)
   );

   assign req_gnt = gnt;

   // route granted requests onto their lanes
   always_comb begin
      add_v   = '0;  add_sub = '0;  add_tag = '0;  add_a = '0;  add_b = '0;
      mul_v   = '0;  mul_tag = '0;  mul_a   = '0;  mul_b = '0;
      for (int u = 0; u < NU; u++) begin
         for (int c = 0; c < NC; c++) begin
            if (gnt[c] && (sel[c] == UW'(u))) begin
               if (want_mul[c]) begin
                  mul_v[u]   = 1'b1;
                  mul_tag[u] = TW'(c);
                  mul_a[u]   = req_a[c];
                  mul_b[u]   = req_b[c];
               end else begin
                  add_v[u]   = 1'b1;
                  add_sub[u] = op_is_sub(req_op[c]);
                  add_tag[u] = TW'(c);
                  add_a[u]   = req_a[c];
                  add_b[u]   = req_b[c];
               end
            end
         end
      end
   end

   for (genvar u = 0; u < NU; u++) begin : g_unit
      fsx_unit #(.DW(DW), .TW(TW), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_unit (
         .clk      (clk),
         .rst_n    (rst_n),
         .add_v    (add_v[u]),
         .add_sub  (add_sub[u]),
         .add_tag  (add_tag[u]),
         .add_a    (add_a[u]),
         .add_b    (add_b[u]),
         .mul_v    (mul_v[u]),
         .mul_tag  (mul_tag[u]),
         .mul_a    (mul_a[u]),
         .mul_b    (mul_b[u]),
         .add_ov   (add_ov[u]),
         .add_otag (add_otag[u]),
         .add_od   (add_od[u]),
         .mul_ov   (mul_ov[u]),
         .mul_otag (mul_otag[u]),
         .mul_od   (mul_od[u])
      );
   end

   // steer every lane's tagged response back to its core
   always_comb begin
      rsp_valid = '0;
      rsp_data  = '0;
      for (int c = 0; c < NC; c++) begin
         for (int u = 0; u < NU; u++) begin
            if (add_ov[u] && (add_otag[u] == TW'(c))) begin
               rsp_valid[c] = 1'b1;
               rsp_data[c]  = rsp_data[c] | add_od[u];
            end
            if (mul_ov[u] && (mul_otag[u] == TW'(c))) begin
               rsp_valid[c] = 1'b1;
               rsp_data[c]  = rsp_data[c] | mul_od[u];
            end
         end
      end
   end

endmodule

// File: rtl/fsx_xbar_chk.sv
// Property checker for fu_share_xbar, attached by bind.
module fsx_xbar_chk #(
   parameter int NC = 4,
   parameter int NU = 2,
   parameter int TW = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NC-1:0]         req_valid,
   input logic [NC-1:0][1:0]    req_op,
   input logic [NC-1:0]         req_gnt,
   input logic [NC-1:0]         rsp_valid,
   input logic [NU-1:0]         add_ov,
   input logic [NU-1:0][TW-1:0] add_otag,
   input logic [NU-1:0]         mul_ov,
   input logic [NU-1:0][TW-1:0] mul_otag
);

   logic [NC-1:0] mul_req;
   for (genvar c = 0; c < NC; c++) begin : g_op
      assign mul_req[c] = req_op[c][1];
   end

   p_gnt_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_gnt & ~req_valid) == '0);

   p_add_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_gnt & ~mul_req) <= NU);

   p_mul_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_gnt & mul_req) <= NU);

   for (genvar c = 0; c < NC; c++) begin : g_core
      logic [2*NU-1:0] hits;
      logic [7:0]      pend_q;

      for (genvar u = 0; u < NU; u++) begin : g_hit
         assign hits[2*u]   = add_ov[u] && (add_otag[u] == TW'(c));
         assign hits[2*u+1] = mul_ov[u] && (mul_otag[u] == TW'(c));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) pend_q <= '0;
         else        pend_q <= pend_q + 8'(req_gnt[c]) - 8'(rsp_valid[c]);
      end

      p_single_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(hits));

      p_rsp_has_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid[c] |-> (pend_q != 8'd0));
   end

endmodule

bind fu_share_xbar fsx_xbar_chk #(.NC(NC), .NU(NU), .TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_gnt   (req_gnt),
   .rsp_valid (rsp_valid),
   .add_ov    (add_ov),
   .add_otag  (add_otag),
   .mul_ov    (mul_ov),
   .mul_otag  (mul_otag)
);

// File: tb/fu_share_xbar_tb.sv
`timescale 1ns/1ps
module fu_share_xbar_tb;

   localparam int CL = 2;
   localparam int UL = 1;
   localparam int NC = 1 << CL;
   localparam int NU = 1 << UL;
   localparam int DW = 16;
   localparam int LA = 2;
   localparam int LM = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                  rst_n;
   logic [NC-1:0]         req_valid;
   logic [NC-1:0][1:0]    req_op;
   logic [NC-1:0][DW-1:0] req_a, req_b;
   logic [NC-1:0]         gnt0, gnt1, rv0, rv1;
   logic [NC-1:0][DW-1:0] rd0, rd1;

   fu_share_xbar #(.CORE_LOG(CL), .UNIT_LOG(UL), .DW(DW), .ADD_LAT(LA), .MUL_LAT(LM),
                   .RANDOM_PICK(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_a(req_a), .req_b(req_b), .req_gnt(gnt0), .rsp_valid(rv0), .rsp_data(rd0));

   fu_share_xbar #(.CORE_LOG(CL), .UNIT_LOG(UL), .DW(DW), .ADD_LAT(LA), .MUL_LAT(LM),
                   .RANDOM_PICK(1'b1)) u_dut_rnd (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_a(req_a), .req_b(req_b), .req_gnt(gnt1), .rsp_valid(rv1), .rsp_data(rd1));

   typedef struct { int core; int due; logic [DW-1:0] data; } exp_t;
   typedef struct { logic [1:0] op; logic [DW-1:0] a; logic [DW-1:0] b; } op_t;

   exp_t sb[$];
   op_t  pend[NC][$];
   int   total = 0, bad = 0, cyc = 0, ptr = 0;
   int   first_g[NC], last_g[NC];
   bit   done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s got=%0h exp=%0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic push_op(input int c, input logic [1:0] op,
                          input logic [DW-1:0] a, input logic [DW-1:0] b);
      op_t o;
      o.op = op; o.a = a; o.b = b;
      pend[c].push_back(o);
   endtask

   function automatic int lat_of(input logic [1:0] op);
      return op[1] ? LM : LA;
   endfunction

   function automatic logic [DW-1:0] ref_res(input logic [1:0] op,
                                             input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [2*DW-1:0] p;
      p = a * b;
      if (op[1])      return p[DW-1:0];
      else if (op[0]) return a - b;
      else            return a + b;
   endfunction

   function automatic bit taken(input int c, input int due);
      foreach (sb[k]) if (sb[k].core == c && sb[k].due == due) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit busy();
      if (sb.size() != 0) return 1'b1;
      for (int c = 0; c < NC; c++) if (pend[c].size() != 0) return 1'b1;
      return 1'b0;
   endfunction

   // monitor: pop expected responses due this cycle and compare both instances
   task automatic monitor();
      for (int c = 0; c < NC; c++) begin
         int idx = -1;
         logic [DW-1:0] ed = '0;
         foreach (sb[k]) if (sb[k].core == c && sb[k].due == cyc) idx = k;
         if (idx >= 0) ed = sb[idx].data;
         check(rv0[c] == (idx >= 0), "R5", "response valid timing", rv0[c], idx >= 0);
         if (idx >= 0) check(rd0[c] == ed, "R3", "result value", rd0[c], ed);
         check(rv1[c] == (idx >= 0), "R8", "random-start response valid", rv1[c], idx >= 0);
         if (idx >= 0) check(rd1[c] == ed, "R8", "random-start result", rd1[c], ed);
         if (idx >= 0) sb.delete(idx);
      end
   endtask

   task automatic drive();
      for (int c = 0; c < NC; c++) begin
         if (pend[c].size() != 0) begin
            req_valid[c] = 1'b1;
            req_op[c]    = pend[c][0].op;
            req_a[c]     = pend[c][0].a;
            req_b[c]     = pend[c][0].b;
         end else begin
            req_valid[c] = 1'b0;
            req_op[c]    = 2'b00;
            req_a[c]     = '0;
            req_b[c]     = '0;
         end
      end
   endtask

   // reference grant model, compared with both instances; grants feed the scoreboard
   task automatic arbitrate();
      logic [NC-1:0] eg = '0;
      logic [NC-1:0] clash = '0;
      bit refused = 1'b0;
      int na = 0, nm = 0;
      for (int i = 0; i < NC; i++) begin
         int c = (ptr + i) % NC;
         if (pend[c].size() != 0) begin
            logic [1:0] op = pend[c][0].op;
            if (taken(c, cyc + lat_of(op))) clash[c] = 1'b1;
            else if (op[1]) begin
               if (nm < NU) begin eg[c] = 1'b1; nm++; end else refused = 1'b1;
            end else begin
               if (na < NU) begin eg[c] = 1'b1; na++; end else refused = 1'b1;
            end
         end
      end
      for (int c = 0; c < NC; c++) begin
         string tag;
         tag = (pend[c].size() == 0) ? "R2" : (clash[c] ? "R6" : "R4/R7");
         check(gnt0[c] == eg[c], tag, "grant", gnt0[c], eg[c]);
         check(gnt1[c] == eg[c], "R8", "random-start grant", gnt1[c], eg[c]);
         if (eg[c]) begin
            exp_t e;
            op_t  o = pend[c].pop_front();
            e.core = c; e.due = cyc + lat_of(o.op); e.data = ref_res(o.op, o.a, o.b);
            sb.push_back(e);
            if (first_g[c] < 0) first_g[c] = cyc;
            last_g[c] = cyc;
         end
      end
      if (refused) ptr = (ptr + 1) % NC;
   endtask

   task automatic clear_track();
      for (int c = 0; c < NC; c++) begin first_g[c] = -1; last_g[c] = -1; end
   endtask

   task automatic drain();
      do @(posedge clk); while (busy());
      repeat (3) @(posedge clk);
   endtask

   // engine: monitor, then drive, then grant sampling, each away from the clock edge
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         cyc++;
         #1 monitor();
         #1 drive();
         #2 arbitrate();
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R9 watchdog got=hung exp=drained");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      clear_track();
      req_valid = '0; req_op = '0; req_a = '0; req_b = '0;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      // R1: no response valid while reset is held
      check(rv0 == '0, "R1", "response valid in reset", rv0, 0);
      check(rv1 == '0, "R1", "random-start response valid in reset", rv1, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(rv0 == '0, "R1", "response valid after reset", rv0, 0);
      check(gnt0 == '0, "R2", "grant without request", gnt0, 0);

      // R3 R5: one operation of each kind on separate cores
      push_op(0, 2'b00, 16'h1234, 16'h0101);
      push_op(1, 2'b01, 16'h0005, 16'h0007);
      push_op(2, 2'b10, 16'h0123, 16'h0456);
      push_op(3, 2'b11, 16'hFFFF, 16'hFFFF);
      drain();

      // R4 R7: four adds against two adders
      for (int c = 0; c < NC; c++) push_op(c, 2'b00, 16'(c * 3), 16'h0010);
      drain();

      // R6: mul, mul, add on one core; the add clashes twice
      clear_track();
      push_op(0, 2'b10, 16'h0003, 16'h0004);
      push_op(0, 2'b10, 16'h0005, 16'h0006);
      push_op(0, 2'b00, 16'h0007, 16'h0008);
      drain();
      check(last_g[0] - first_g[0] == 4, "R6", "clash delay of add issue",
            last_g[0] - first_g[0], 4);

      // R9: back-to-back multiplies from one core
      clear_track();
      for (int k = 0; k < 8; k++) push_op(1, 2'b10, 16'(k + 2), 16'h0101);
      drain();
      check(last_g[1] - first_g[1] == 7, "R9", "consecutive issue span",
            last_g[1] - first_g[1], 7);

      // mixed traffic from a bench-side LFSR
      lf = 16'h1D3B;
      for (int k = 0; k < 160; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         push_op(int'(lf[1:0]), lf[3:2], {lf[7:0], lf[15:8]}, lf ^ 16'h5A5A);
      end
      drain();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule